// File: doc/BRIEF.md
# Debug-Aware Port Mapper for a Single-Read, Single-Write Memory

This block sits in front of a storage array that has one read port and one write port. Several functional write requesters and several functional read requesters share those two ports. In normal operation each port goes to the lowest-indexed requester that is asking for it, and the block reports that choice on a grant vector.

The storage cannot take an extra access path of its own, so a debugger reaches it through the same two ports. When the run enable input is low, the core is halted. In that state no functional requester is granted, which keeps the memory contents exactly as the halted core left them. A debug read or a debug write is then steered onto the matching port.

Reads are synchronous with one cycle of latency. The word that was read appears on a shared data bus. A valid flag tells which consumer it belongs to: one flag per functional reader, plus one flag for the debugger. A behavioural memory model is included so the block can be tested on its own.

Top module: `mem_dbg_port_mapper`

## Requirements
- R1: After reset, no functional read valid flag and no debug read valid flag is asserted.
- R2: With run_en high, the write port is granted to the lowest-indexed requesting functional writer, and only that writer's data is stored, at that writer's address.
- R3: With run_en high, the read port is granted to the lowest-indexed requesting functional reader. On the next cycle, bit i of fr_valid is set for that reader only, and fr_rdata holds the word read from its address.
- R4: With run_en low, no functional write is granted and memory contents are left unchanged by functional write requests.
- R5: With run_en low, no functional read is granted and no fr_valid bit is set on the following cycle.
- R6: With run_en low, a debug write (dbg_wr high) stores dbg_wdata at dbg_addr.
- R7: With run_en low, a debug read (dbg_rd high) sets dbg_rvalid on the next cycle, with dbg_rdata holding the word at dbg_addr.
- R8: With run_en high, debug writes and reads are ignored: memory is unchanged and dbg_rvalid stays low.
- R9: A read and a write to the same address in the same cycle return the word held before that write.
- R10: Each grant vector (fw_gnt, fr_gnt) has at most one bit set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | 1 = core running, 0 = halted (debug mode) |
| fw_req | input | N_WR | Functional write requests, bit 0 highest priority |
| fw_addr | input | N_WR*ADDR_W | Write addresses, requester i in slice i |
| fw_data | input | N_WR*DATA_W | Write data, requester i in slice i |
| fw_gnt | output | N_WR | One-hot write grant |
| fr_req | input | N_RD | Functional read requests, bit 0 highest priority |
| fr_addr | input | N_RD*ADDR_W | Read addresses, requester i in slice i |
| fr_gnt | output | N_RD | One-hot read grant |
| fr_valid | output | N_RD | Read data valid, per requester, one cycle after grant |
| fr_rdata | output | DATA_W | Read data for functional readers |
| dbg_wr | input | 1 | Debug write request |
| dbg_rd | input | 1 | Debug read request |
| dbg_addr | input | ADDR_W | Debug address |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_rvalid | output | 1 | Debug read data valid |
| dbg_rdata | output | DATA_W | Debug read data |

## Verification
The hardest cases to reach are those where nothing may happen: a functional write during halt, and a debug write while the core runs. Neither shows up on any port in the cycle it occurs. The bench first stores a known word and then issues the forbidden write. It then reads the location back through whichever path is allowed in the current mode, and compares the result with the earlier word. A second hard case is a read and a write to the same address in the same cycle. The bench drives both in one cycle and checks that the old word is returned, then that the new word is returned on the following read.

// File: rtl/mdpm_pkg.sv
package mdpm_pkg;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_HALT = 1'b1
    } mode_e;

endpackage

// File: rtl/mdpm_prio_pick.sv
module mdpm_prio_pick #(
    parameter int N = 2
) (
    input  logic         enable,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // prefix chain: taken[i] is set when any lower index requests
    logic [N:0] taken;
    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt[i]     = enable & req[i] & ~taken[i];
        assign taken[i+1] = taken[i] | req[i];
    end
endmodule

// File: rtl/mdpm_onehot_mux.sv
module mdpm_onehot_mux #(
    parameter int N = 2,
    parameter int W = 8
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] din,
    output logic [W-1:0]   dout
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            dout = dout | (din[i*W +: W] & {W{sel[i]}});
        end
    end
endmodule

// File: rtl/mdpm_ram.sv
module mdpm_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    // read samples the array before this edge's write lands
    always_comb begin
        rdata_d = re ? mem[raddr] : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/mem_dbg_port_mapper.sv
module mem_dbg_port_mapper
    import mdpm_pkg::*;
#(
    parameter int N_WR   = 3,
    parameter int N_RD   = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic [N_WR-1:0]          fw_req,
    input  logic [N_WR*ADDR_W-1:0]   fw_addr,
    input  logic [N_WR*DATA_W-1:0]   fw_data,
    output logic [N_WR-1:0]          fw_gnt,
    input  logic [N_RD-1:0]          fr_req,
    input  logic [N_RD*ADDR_W-1:0]   fr_addr,
    output logic [N_RD-1:0]          fr_gnt,
    output logic [N_RD-1:0]          fr_valid,
    output logic [DATA_W-1:0]        fr_rdata,
    input  logic                     dbg_wr,
    input  logic                     dbg_rd,
    input  logic [ADDR_W-1:0]        dbg_addr,
    input  logic [DATA_W-1:0]        dbg_wdata,
    output logic                     dbg_rvalid,
    output logic [DATA_W-1:0]        dbg_rdata
);
    typedef struct packed {
        logic [N_RD-1:0] fr_vld;
        logic            dbg_vld;
    } vld_t;

    mode_e mode;
    assign mode = run_en ? MODE_RUN : MODE_HALT;

    logic run_ok;
    assign run_ok = (mode == MODE_RUN);

    // priority selection, disabled while halted
    mdpm_prio_pick #(.N(N_WR)) u_wr_pick (
        .enable (run_ok),
        .req    (fw_req),
        .gnt    (fw_gnt)
    );

    mdpm_prio_pick #(.N(N_RD)) u_rd_pick (
        .enable (run_ok),
        .req    (fr_req),
        .gnt    (fr_gnt)
    );

    logic [ADDR_W-1:0] fw_sel_addr;
    logic [DATA_W-1:0] fw_sel_data;
    logic [ADDR_W-1:0] fr_sel_addr;

    mdpm_onehot_mux #(.N(N_WR), .W(ADDR_W)) u_wa_mux (
        .sel (fw_gnt), .din (fw_addr), .dout (fw_sel_addr)
    );
    mdpm_onehot_mux #(.N(N_WR), .W(DATA_W)) u_wd_mux (
        .sel (fw_gnt), .din (fw_data), .dout (fw_sel_data)
    );
    mdpm_onehot_mux #(.N(N_RD), .W(ADDR_W)) u_ra_mux (
        .sel (fr_gnt), .din (fr_addr), .dout (fr_sel_addr)
    );

    // port steering: debug bypass when halted
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    vld_t vld_d, vld_q;

    always_comb begin
        if (mode == MODE_HALT) begin
            mem_we    = dbg_wr;
            mem_waddr = dbg_addr;
            mem_wdata = dbg_wdata;
            mem_re    = dbg_rd;
            mem_raddr = dbg_addr;
        end else begin
            mem_we    = |fw_gnt;
            mem_waddr = fw_sel_addr;
            mem_wdata = fw_sel_data;
            mem_re    = |fr_gnt;
            mem_raddr = fr_sel_addr;
        end
        vld_d.fr_vld  = fr_gnt;
        vld_d.dbg_vld = (mode == MODE_HALT) & dbg_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    mdpm_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign fr_valid   = vld_q.fr_vld;
    assign dbg_rvalid = vld_q.dbg_vld;
    assign fr_rdata   = mem_rdata;
    assign dbg_rdata  = mem_rdata;
endmodule

// File: rtl/mdpm_checker.sv
module mdpm_checker #(
    parameter int N_WR = 3,
    parameter int N_RD = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic            dbg_rd,
    input logic [N_WR-1:0] fw_gnt,
    input logic [N_RD-1:0] fr_gnt,
    input logic [N_RD-1:0] fr_valid,
    input logic            dbg_rvalid
);
    assert_wr_gnt_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fw_gnt));

    assert_rd_gnt_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fr_gnt));

    assert_halt_blocks_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (fw_gnt == '0));

    assert_halt_blocks_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (fr_valid == '0));

    assert_valid_follows_gnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|fr_gnt) |=> (fr_valid == $past(fr_gnt)));

    assert_dbg_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && dbg_rd) |=> dbg_rvalid);

    assert_dbg_ignored_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> !dbg_rvalid);
endmodule

bind mem_dbg_port_mapper mdpm_checker #(.N_WR(N_WR), .N_RD(N_RD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .dbg_rd     (dbg_rd),
    .fw_gnt     (fw_gnt),
    .fr_gnt     (fr_gnt),
    .fr_valid   (fr_valid),
    .dbg_rvalid (dbg_rvalid)
);

// File: tb/mem_dbg_port_mapper_tb.sv
module mem_dbg_port_mapper_tb;
    localparam int NW = 3;
    localparam int NR = 2;
    localparam int AW = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b1;
    logic [NW-1:0]    fw_req = '0;
    logic [NW*AW-1:0] fw_addr = '0;
    logic [NW*DW-1:0] fw_data = '0;
    logic [NW-1:0]    fw_gnt;
    logic [NR-1:0]    fr_req = '0;
    logic [NR*AW-1:0] fr_addr = '0;
    logic [NR-1:0]    fr_gnt;
    logic [NR-1:0]    fr_valid;
    logic [DW-1:0]    fr_rdata;
    logic             dbg_wr = 1'b0;
    logic             dbg_rd = 1'b0;
    logic [AW-1:0]    dbg_addr = '0;
    logic [DW-1:0]    dbg_wdata = '0;
    logic             dbg_rvalid;
    logic [DW-1:0]    dbg_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    mem_dbg_port_mapper #(.N_WR(NW), .N_RD(NR), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .fw_req(fw_req), .fw_addr(fw_addr), .fw_data(fw_data), .fw_gnt(fw_gnt),
        .fr_req(fr_req), .fr_addr(fr_addr), .fr_gnt(fr_gnt),
        .fr_valid(fr_valid), .fr_rdata(fr_rdata),
        .dbg_wr(dbg_wr), .dbg_rd(dbg_rd), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rvalid(dbg_rvalid), .dbg_rdata(dbg_rdata)
    );

    // run_en | fw_req | fr_req | dbg_wr | dbg_rd | exp fw_gnt | exp fr_gnt
    localparam int NV = 8;
    localparam logic [12:0] VEC [NV] = '{
        13'b1_111_11_0_0_001_01,
        13'b1_110_10_0_0_010_10,
        13'b1_100_00_0_0_100_00,
        13'b1_000_01_1_1_000_01,
        13'b1_101_11_0_0_001_01,
        13'b0_111_11_1_1_000_00,
        13'b0_010_10_0_0_000_00,
        13'b1_011_00_0_0_001_00
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        fw_req = '0; fr_req = '0; dbg_wr = 1'b0; dbg_rd = 1'b0;
    endtask

    task automatic fw_write(input int idx, input logic [AW-1:0] a, input logic [DW-1:0] d);
        fw_req = '0;
        fw_req[idx] = 1'b1;
        fw_addr[idx*AW +: AW] = a;
        fw_data[idx*DW +: DW] = d;
        tick();
        fw_req = '0;
    endtask

    task automatic fr_read(input int idx, input logic [AW-1:0] a,
                           output logic [DW-1:0] d, output logic [NR-1:0] v);
        fr_req = '0;
        fr_req[idx] = 1'b1;
        fr_addr[idx*AW +: AW] = a;
        tick();
        fr_req = '0;
        d = fr_rdata;
        v = fr_valid;
    endtask

    task automatic dbg_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
        dbg_rd = 1'b1; dbg_addr = a;
        tick();
        dbg_rd = 1'b0;
        d = dbg_rdata;
        v = dbg_rvalid;
    endtask

    initial begin
        #(8 * 100000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        logic [NR-1:0] v;
        logic          dv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 fr_valid after reset", 32'(fr_valid), 0);
        chk("R1 dbg_rvalid after reset", 32'(dbg_rvalid), 0);

        // vector table: grant selection, R2 R3 R4 R5 R10
        for (int k = 0; k < NV; k++) begin
            fw_addr   = {NW{4'hF}};
            fr_addr   = {NR{4'hF}};
            dbg_addr  = 4'hE;
            run_en    = VEC[k][12];
            fw_req    = VEC[k][11:9];
            fr_req    = VEC[k][8:7];
            dbg_wr    = VEC[k][6];
            dbg_rd    = VEC[k][5];
            #1;
            chk($sformatf("R2/R4/R10 fw_gnt vec %0d", k), 32'(fw_gnt), 32'(VEC[k][4:2]));
            chk($sformatf("R3/R5/R10 fr_gnt vec %0d", k), 32'(fr_gnt), 32'(VEC[k][1:0]));
            tick();
        end
        idle();
        run_en = 1'b1;
        tick();

        // R2: two writers collide, lower index stored only
        fw_write(0, 4'd6, 8'h00);
        fw_req = 3'b110;
        fw_addr[1*AW +: AW] = 4'd5; fw_data[1*DW +: DW] = 8'hA1;
        fw_addr[2*AW +: AW] = 4'd6; fw_data[2*DW +: DW] = 8'hB2;
        tick();
        fw_req = '0;
        fr_read(0, 4'd5, d, v);
        chk("R2 winner data stored", 32'(d), 32'hA1);
        fr_read(0, 4'd6, d, v);
        chk("R2 loser not stored", 32'(d), 32'h00);

        // R3: two readers, lower index gets data and valid
        fr_req = 2'b11;
        fr_addr[0 +: AW] = 4'd5; fr_addr[AW +: AW] = 4'd6;
        tick();
        chk("R3 valid to reader 0", 32'(fr_valid), 32'b01);
        chk("R3 data for reader 0", 32'(fr_rdata), 32'hA1);
        fr_req = 2'b10;
        tick();
        chk("R3 valid to reader 1", 32'(fr_valid), 32'b10);
        chk("R3 data for reader 1", 32'(fr_rdata), 32'h00);
        fr_req = '0;
        tick();
        chk("R3 valid drops when idle", 32'(fr_valid), 0);

        // R4 / R7: halted, functional write blocked, debug read sees old word
        run_en = 1'b0;
        fw_write(0, 4'd5, 8'h33);
        dbg_read(4'd5, d, dv);
        chk("R4 functional write blocked in halt", 32'(d), 32'hA1);
        chk("R7 dbg_rvalid one cycle after read", 32'(dv), 1);

        // R5: functional read blocked in halt
        fr_read(1, 4'd5, d, v);
        chk("R5 no fr_valid in halt", 32'(v), 0);

        // R6: debug write then readback
        dbg_wr = 1'b1; dbg_addr = 4'd7; dbg_wdata = 8'h77;
        tick();
        dbg_wr = 1'b0;
        dbg_read(4'd7, d, dv);
        chk("R6 debug write stored", 32'(d), 32'h77);
        chk("R7 dbg_rvalid on readback", 32'(dv), 1);
        tick();
        chk("R7 dbg_rvalid drops", 32'(dbg_rvalid), 0);

        // R8: debug access ignored while running
        run_en = 1'b1;
        dbg_wr = 1'b1; dbg_rd = 1'b1; dbg_addr = 4'd7; dbg_wdata = 8'h11;
        tick();
        chk("R8 dbg_rvalid stays low in run", 32'(dbg_rvalid), 0);
        idle();
        fr_read(0, 4'd7, d, v);
        chk("R8 debug write ignored in run", 32'(d), 32'h77);

        // R9: same-address read and write in one cycle
        fw_req = 3'b001; fw_addr[0 +: AW] = 4'd7; fw_data[0 +: DW] = 8'h99;
        fr_req = 2'b01;  fr_addr[0 +: AW] = 4'd7;
        tick();
        idle();
        chk("R9 collision returns old word", 32'(fr_rdata), 32'h77);
        chk("R9 collision valid", 32'(fr_valid), 32'b01);
        fr_read(0, 4'd7, d, v);
        chk("R9 new word visible after", 32'(d), 32'h99);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule